// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a byte-wide, register-mapped coprocessor that runs a two-dimensional forward discrete cosine transform over one 8x8 tile of signed 16-bit samples. It uses integer arithmetic only. The host loads the tile one byte at a time, writes a start command and polls a busy flag. When the flag clears, it unloads the 64 transformed values, again one byte at a time.

Inside, a single signed multiplier is time-shared by a small sequencer. The first pass forms one partial sum for every (row, frequency) pair and keeps it in a scratch buffer. The second pass combines those partial sums down each column. A final multiply by a small normalisation constant gives each output. Every product is scaled back by an arithmetic right shift. The cosine coefficients carry 6 fractional bits.

Top module: `fdct_copro`

## Requirements
- R1: The host bus uses a 2-bit address: 0 = status (bit 0 = busy, other bits 0), 1 = command, 2 = data-in, 3 = data-out. Read data appears on `busRdData` in the cycle after the read strobe. It is 0 for reads of the command and data-in addresses and for cycles without a read.
- R2: On the data-in address, a write of the upper byte and then a write of the lower byte form one signed 16-bit sample. The lower-byte write stores the sample, multiplied by 64, at the next load position. That position is 8*row+col (row-major), and it wraps from 63 back to 0.
- R3: Writing the value 0x01 to the command address while idle starts a transform. Any other value, or any command write while busy, is ignored. A start clears both the load and unload positions and their byte phases.
- R4: Status bit 0 reads 1 for exactly 1088 cycles. It first reads 1 on a status read strobed in the cycle after the start write, and it reads 0 on the next read after that window.
- R5: Row pass: s[x][v] = sum over j of ((in[x][j]*64) * c[j][v]) >>> 6. Here c[j][v] is 64*cos((2j+1)*v*pi/16) truncated toward zero, which gives 64,62,59,53,45,35,24,12 for j=0, v=0..7.
- R6: Column pass: r[u][v] = sum over x of (s[x][v] * c[x][u]) >>> 6. All sums are signed and at least 32 bits wide.
- R7: Normalisation: out[u][v] is the low 16 bits of (r[u][v] * K) >>> 18, with K = ((16*C(u))>>6)*C(v) and C(h) = 5 for h = 0, else 64. This gives K = 5, 64, 80 or 1024.
- R8: On the data-out address, each result is read as its upper byte and then its lower byte. The position is 8*u+v, it advances after the lower byte, and it wraps from 63 back to 0.
- R9: Data-in writes while busy are ignored. The stored tile is unchanged, so a restart without new loads gives the same results.
- R10: Data-out reads while busy return 0 and do not move the unload position.
- R11: After reset the block is idle, both positions are 0, and every stored result reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | BUS_W | Write data byte |
| busRdEn | input | 1 | Single-cycle read strobe |
| busRdData | output | BUS_W | Read data, valid the cycle after the strobe |

## Verification
The bench drives tiles that stress the arithmetic: all-zero, full-scale positive and negative constants, a ramp, a checkerboard, a single impulse off the diagonal, and pseudo-random tiles. Each output is compared against a model built from the formulas above.
- A lost sign extension or a logical shift in place of an arithmetic one corrupts the negative tiles.
- A wrong scale constant or swapped row and column indices corrupts the DC and edge terms, and the impulse tile shows up a transposed index.
- An off-by-one in the sequencer moves the busy window away from 1088 cycles.

Protocol corners are also exercised:
- Loading 128 samples without a start checks that the load position wraps.
- A restart after a partial unload checks that the unload position is cleared.
- Loads and unloads during busy check that neither is accepted and that the unload position does not move.
- Command values other than 1 check that they are ignored.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int BLK = 8;
  localparam int IDX_W = $clog2(BLK);
  localparam int ELEM_W = 2 * IDX_W;
  localparam int FRAC = 6;
  localparam int COEF_W = 12;
  localparam int NORM_SHIFT = 3 * FRAC;
  localparam int BUSY_CYCLES = BLK * BLK * BLK + BLK * BLK * (BLK + 1);

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CMD  = 2'd1;
  localparam logic [1:0] ADDR_DIN  = 2'd2;
  localparam logic [1:0] ADDR_DOUT = 2'd3;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic              pushHi;
    logic              pushLo;
    logic [ELEM_W-1:0] pushPos;
    logic              rdStat;
    logic              rdDoutHi;
    logic              rdDoutLo;
    logic [ELEM_W-1:0] popPos;
    logic              busy;
    logic              macRow;
    logic              macCol;
    logic              doScale;
    logic              lastTerm;
    logic [ELEM_W-1:0] elem;
    logic [IDX_W-1:0]  inner;
  } ctrl_t;

  function automatic int cosBase(input int m);
    case (m)
      0: return 64;
      1: return 62;
      2: return 59;
      3: return 53;
      4: return 45;
      5: return 35;
      6: return 24;
      7: return 12;
      default: return 0;
    endcase
  endfunction

  // 64*cos((2*pos+1)*freq*pi/16), truncated (R5)
  function automatic logic signed [COEF_W-1:0] cosCoef(input logic [IDX_W-1:0] pos,
                                                      input logic [IDX_W-1:0] freq);
    int k;
    int val;
    k = ((2 * int'(pos) + 1) * int'(freq)) % (4 * BLK);
    if (k <= BLK) val = cosBase(k);
    else if (k <= 2 * BLK) val = -cosBase(2 * BLK - k);
    else if (k <= 3 * BLK) val = -cosBase(k - 2 * BLK);
    else val = cosBase(4 * BLK - k);
    return COEF_W'(val);
  endfunction

  // normalisation constant (R7)
  function automatic logic signed [COEF_W-1:0] scaleK(input logic [IDX_W-1:0] u,
                                                     input logic [IDX_W-1:0] v);
    int cu;
    int cv;
    cu = (u == '0) ? 5 : 64;
    cv = (v == '0) ? 5 : 64;
    return COEF_W'(((16 * cu) >> FRAC) * cv);
  endfunction
endpackage

// File: rtl/fdct_ctrl.sv
module fdct_ctrl
  import fdct_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             busRdEn,
  output ctrl_t            ctl
);
  typedef enum logic [1:0] {S_IDLE, S_ROW, S_COL, S_SCALE} state_t;

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BLK - 1);
  localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(BLK * BLK - 1);

  state_t            state;
  logic [ELEM_W-1:0] elem;
  logic [IDX_W-1:0]  inner;
  logic [ELEM_W-1:0] pushPos;
  logic [ELEM_W-1:0] popPos;
  logic              pushPhase;
  logic              popPhase;
  logic              idle;
  logic              startReq;
  logic              dinWr;
  logic              doutRd;

  assign idle     = (state == S_IDLE);
  // R3: only value 1 while idle starts
  assign startReq = busWrEn && busAddr == ADDR_CMD && busWrData == BUS_W'(1) && idle;
  // R9: loads only while idle
  assign dinWr    = busWrEn && busAddr == ADDR_DIN && idle;
  // R10: unloads only while idle
  assign doutRd   = busRdEn && busAddr == ADDR_DOUT && idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      elem      <= '0;
      inner     <= '0;
      pushPos   <= '0;
      popPos    <= '0;
      pushPhase <= 1'b0;
      popPhase  <= 1'b0;
    end else begin
      if (dinWr) begin
        pushPhase <= ~pushPhase;
        if (pushPhase) pushPos <= pushPos + 1'b1;  // R2 wraps at 64
      end
      if (doutRd) begin
        popPhase <= ~popPhase;
        if (popPhase) popPos <= popPos + 1'b1;     // R8 wraps at 64
      end
      case (state)
        S_ROW: begin
          inner <= inner + 1'b1;
          if (inner == LAST_IDX) begin
            elem <= elem + 1'b1;
            if (elem == LAST_ELEM) state <= S_COL;
          end
        end
        S_COL: begin
          inner <= inner + 1'b1;
          if (inner == LAST_IDX) state <= S_SCALE;
        end
        S_SCALE: begin
          elem  <= elem + 1'b1;
          state <= (elem == LAST_ELEM) ? S_IDLE : S_COL;
        end
        default: ;
      endcase
      if (startReq) begin
        state     <= S_ROW;
        elem      <= '0;
        inner     <= '0;
        pushPos   <= '0;
        popPos    <= '0;
        pushPhase <= 1'b0;
        popPhase  <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.pushHi   = dinWr && !pushPhase;
    ctl.pushLo   = dinWr && pushPhase;
    ctl.pushPos  = pushPos;
    ctl.rdStat   = busRdEn && busAddr == ADDR_STAT;
    ctl.rdDoutHi = doutRd && !popPhase;
    ctl.rdDoutLo = doutRd && popPhase;
    ctl.popPos   = popPos;
    ctl.busy     = !idle;
    ctl.macRow   = (state == S_ROW);
    ctl.macCol   = (state == S_COL);
    ctl.doScale  = (state == S_SCALE);
    ctl.lastTerm = (inner == LAST_IDX);
    ctl.elem     = elem;
    ctl.inner    = inner;
  end
endmodule

// File: rtl/fdct_dpath.sv
module fdct_dpath
  import fdct_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData
);
  localparam int DATA_W = 2 * BUS_W;
  localparam int IN_W   = DATA_W + FRAC;
  localparam int PROD_W = ACC_W + COEF_W;
  localparam int ENTRIES = BLK * BLK;

  logic signed [IN_W-1:0]   inBuf  [ENTRIES];
  logic signed [ACC_W-1:0]  sBuf   [ENTRIES];
  logic signed [DATA_W-1:0] outBuf [ENTRIES];

  logic [BUS_W-1:0]         hiByte;
  logic signed [DATA_W-1:0] sample;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  opA;
  logic signed [COEF_W-1:0] opB;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum;
  logic [IDX_W-1:0]         hiIdx;
  logic [IDX_W-1:0]         loIdx;

  assign hiIdx  = ctl.elem[ELEM_W-1:IDX_W];
  assign loIdx  = ctl.elem[IDX_W-1:0];
  assign sample = {hiByte, busWrData};

  // shared multiplier operand select
  always_comb begin
    opA = acc;
    opB = scaleK(hiIdx, loIdx);
    if (ctl.macRow) begin
      opA = ACC_W'(inBuf[{hiIdx, ctl.inner}]);
      opB = cosCoef(ctl.inner, loIdx);
    end else if (ctl.macCol) begin
      opA = sBuf[{ctl.inner, loIdx}];
      opB = cosCoef(ctl.inner, hiIdx);
    end
  end

  assign prod = opA * opB;
  assign sum  = ACC_W'(acc + (prod >>> FRAC));

  // host load path (R2)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte <= '0;
      for (int i = 0; i < ENTRIES; i++) inBuf[i] <= '0;
    end else begin
      if (ctl.pushHi) hiByte <= busWrData;
      if (ctl.pushLo) inBuf[ctl.pushPos] <= IN_W'(sample) <<< FRAC;
    end
  end

  // accumulate, row results, normalised results (R5 R6 R7)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      for (int i = 0; i < ENTRIES; i++) outBuf[i] <= '0;
    end else if (ctl.macRow) begin
      acc <= ctl.lastTerm ? '0 : sum;
    end else if (ctl.macCol) begin
      acc <= sum;
    end else if (ctl.doScale) begin
      outBuf[ctl.elem] <= DATA_W'(prod >>> NORM_SHIFT);
      acc <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.macRow && ctl.lastTerm) sBuf[ctl.elem] <= sum;
  end

  // registered read data (R1 R8)
  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else if (ctl.rdStat) busRdData <= BUS_W'(ctl.busy);
    else if (ctl.rdDoutHi) busRdData <= outBuf[ctl.popPos][DATA_W-1:BUS_W];
    else if (ctl.rdDoutLo) busRdData <= outBuf[ctl.popPos][BUS_W-1:0];
    else busRdData <= '0;
  end
endmodule

// File: rtl/fdct_copro.sv
module fdct_copro
  import fdct_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic [BUS_W-1:0] busWrData,
  input  logic             busRdEn,
  output logic [BUS_W-1:0] busRdData
);
  ctrl_t ctl;
  logic  busy;

  assign busy = ctl.busy;

  fdct_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .ctl       (ctl)
  );

  fdct_dpath #(.BUS_W(BUS_W), .ACC_W(ACC_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );
endmodule

// File: rtl/fdct_copro_chk.sv
module fdct_copro_chk
  import fdct_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWrEn,
  input logic [BUS_W-1:0] busWrData,
  input logic             busRdEn,
  input logic [BUS_W-1:0] busRdData,
  input logic             busy
);
  logic [15:0] busyCnt;
  logic        startCmd;

  assign startCmd = busWrEn && busAddr == ADDR_CMD && busWrData == BUS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy) |=> busy);

  p_stay_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startCmd) |=> !busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == 16'(BUSY_CYCLES)));

  p_status_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_STAT) |=> (busRdData == BUS_W'($past(busy))));

  p_quiet_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == ADDR_CMD || busAddr == ADDR_DIN)) |=> (busRdData == '0));

  p_dout_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_DOUT && busy) |=> (busRdData == '0));
endmodule

bind fdct_copro fdct_copro_chk u_chk (.*);

// File: tb/fdct_copro_tb.sv
module fdct_copro_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nFail = 0;
  int coefT [8][8];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  fdct_copro u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  function automatic int nextSample();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'($signed(seed[23:8]));
  endfunction

  function automatic int kOf(input int u, input int v);
    int cu;
    int cv;
    cu = (u == 0) ? 5 : 64;
    cv = (v == 0) ? 5 : 64;
    return ((16 * cu) >> 6) * cv;
  endfunction

  // model from R5 R6 R7
  function automatic void refFdct(input int smp[64], output int res[64]);
    longint s [64];
    longint r;
    longint p;
    for (int x = 0; x < 8; x++)
      for (int v = 0; v < 8; v++) begin
        s[x*8+v] = 0;
        for (int j = 0; j < 8; j++)
          s[x*8+v] += ((longint'(smp[x*8+j]) <<< 6) * longint'(coefT[j][v])) >>> 6;
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        r = 0;
        for (int x = 0; x < 8; x++) r += (s[x*8+v] * longint'(coefT[x][u])) >>> 6;
        p = (r * longint'(kOf(u, v))) >>> 18;
        res[u*8+v] = int'(shortint'(p[15:0]));
      end
  endfunction

  task automatic pushTile(input int smp[64]);
    for (int i = 0; i < 64; i++) begin
      wrByte(2'd2, smp[i][15:8]);
      wrByte(2'd2, smp[i][7:0]);
    end
  endtask

  task automatic popOne(output int val);
    logic [7:0] hi;
    logic [7:0] lo;
    rdByte(2'd3, hi);
    rdByte(2'd3, lo);
    val = int'($signed({hi, lo}));
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int i = 0; i < 3000; i++) begin
      rdByte(2'd0, st);
      if (st[0] == 1'b0) return;
    end
    check("R4 busy never cleared", 1, 0);
  endtask

  task automatic popCompare(input int smp[64], input string req);
    int exp [64];
    int got;
    refFdct(smp, exp);
    for (int i = 0; i < 64; i++) begin
      popOne(got);
      check(req, got, exp[i]);
    end
  endtask

  task automatic runTile(input int smp[64], input string req);
    pushTile(smp);
    wrByte(2'd1, 8'd1);
    waitIdle();
    popCompare(smp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R4 actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int tile [64];
    int tileB [64];
    int got;
    logic [7:0] d;

    // R5 coefficients: 64*cos truncated toward zero
    for (int j = 0; j < 8; j++)
      for (int v = 0; v < 8; v++)
        coefT[j][v] = $rtoi(64.0 * $cos((2.0 * j + 1.0) * v * 3.14159265358979 / 16.0));

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    rdByte(2'd0, d);
    check("R11 status after reset", int'(d), 0);
    popOne(got);
    check("R11 result after reset", got, 0);

    // R1 quiet reads
    rdByte(2'd1, d);
    check("R1 command read", int'(d), 0);

    // R4 exact busy window on a ramp tile
    for (int i = 0; i < 64; i++) tile[i] = i * 517 - 16000;
    pushTile(tile);
    wrByte(2'd1, 8'd1);
    rdByte(2'd0, d);
    check("R4 busy after start", int'(d[0]), 1);
    repeat (1086) @(negedge clk);
    rdByte(2'd0, d);
    check("R4 busy on last cycle", int'(d[0]), 1);
    rdByte(2'd0, d);
    check("R4 idle after window", int'(d[0]), 0);
    popCompare(tile, "R7 ramp");

    // R8 unload position wraps
    popOne(got);
    begin
      int exp [64];
      refFdct(tile, exp);
      check("R8 wrap to first result", got, exp[0]);
    end

    // fixed patterns for R5 R6 R7
    for (int i = 0; i < 64; i++) tile[i] = 0;
    runTile(tile, "R7 zero tile");
    for (int i = 0; i < 64; i++) tile[i] = 100;
    runTile(tile, "R7 constant");
    for (int i = 0; i < 64; i++) tile[i] = 32767;
    runTile(tile, "R7 max tile");
    for (int i = 0; i < 64; i++) tile[i] = -32768;
    runTile(tile, "R6 min tile");
    for (int i = 0; i < 64; i++) tile[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 20000 : -20000;
    runTile(tile, "R5 checkerboard");
    for (int i = 0; i < 64; i++) tile[i] = (i == 11) ? 9000 : 0;
    runTile(tile, "R2 impulse row1 col3");
    for (int n = 0; n < 5; n++) begin
      for (int i = 0; i < 64; i++) tile[i] = nextSample();
      runTile(tile, "R6 random");
    end

    // R3 other command values ignored
    wrByte(2'd1, 8'd2);
    rdByte(2'd0, d);
    check("R3 value 2 ignored", int'(d[0]), 0);

    // R9 R10 activity while busy
    for (int i = 0; i < 64; i++) tile[i] = nextSample();
    pushTile(tile);
    wrByte(2'd1, 8'd1);
    wrByte(2'd2, 8'h7f);
    wrByte(2'd2, 8'h11);
    wrByte(2'd1, 8'd1);
    rdByte(2'd3, d);
    check("R10 dout during busy", int'(d), 0);
    rdByte(2'd3, d);
    check("R10 dout during busy", int'(d), 0);
    waitIdle();
    popCompare(tile, "R10 pop from position 0");

    // R3 start clears unload position after partial pop; R9 tile kept
    for (int i = 0; i < 3; i++) popOne(got);
    wrByte(2'd1, 8'd1);
    waitIdle();
    popCompare(tile, "R9 restart same tile");

    // R2 load wrap: 128 samples, second tile wins
    for (int i = 0; i < 64; i++) tileB[i] = nextSample();
    for (int i = 0; i < 64; i++) tile[i] = nextSample();
    pushTile(tileB);
    pushTile(tile);
    wrByte(2'd1, 8'd1);
    waitIdle();
    popCompare(tile, "R2 load wrap");

    // R3 start clears load position
    wrByte(2'd2, 8'h12);
    wrByte(2'd2, 8'h34);
    wrByte(2'd2, 8'h56);
    wrByte(2'd1, 8'd1);
    waitIdle();
    for (int i = 0; i < 64; i++) tile[i] = nextSample();
    runTile(tile, "R3 load restart");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule